// File: doc/BRIEF.md
# Register-Controlled Functional Clock Gate

This block decides whether one functional clock runs. It produces a clock-enable for a downstream gating cell and a status flag that trails that enable by a few cycles, standing in for the time a real gate needs to settle. Software writes a 32-bit control word and reads the same word back. The status flag appears in the read data, so a driver can poll it until it matches the state it asked for.

The gate is built in one of four variants, chosen by a parameter. A no-gate build keeps the clock running at all times. A hardware-only build follows an auto-gate request from an idle detector. A software-only build follows an enable bit. A selectable build lets a select bit choose between the hardware request and the software enable. A further build option, "never off under software", makes the selectable gate run whenever software owns it, whatever the enable bit holds.

Top module: `cg_gate`

## Requirements
- R1: With MODE = no-gate, `clk_en` and `gate_status` are 1 at all times. Writes have no effect, and `rd_data` always reads 0x0000_0010.
- R2: The control word has three defined bits: enable at bit 0, select at bit 1, and the read-only status at bit 4. Every other bit reads 0, and writing to it has no effect. Bits that the built mode does not implement (enable in hardware-only and no-gate; select in every mode other than selectable) read 0.
- R3: With MODE = hardware-only, `clk_en` follows `hw_req` through a two-flop synchroniser. A change on `hw_req` before rising edge N appears on `clk_en` after edge N+1.
- R4: With MODE = software-only, `clk_en` equals the enable bit. A write takes effect right after the rising edge that captures it.
- R5: With MODE = selectable, select = 0 puts `clk_en` under the synchronised `hw_req`, and the enable bit is then ignored. Select = 1 puts `clk_en` on the enable bit, and `hw_req` is then ignored.
- R6: With MODE = selectable and NO_DISABLE = 1, `clk_en` is 1 whenever select = 1, whatever the enable bit holds.
- R7: `gate_status` takes the value of `clk_en` SETTLE rising edges after `clk_en` changes. SETTLE is clamped to the range 2 to 4.
- R8: After a synchronous active-low reset: a selectable gate reads enable = 1 and select = 1, with `clk_en` = 1 and status = 1. A software-only gate reads enable = 1, with `clk_en` = 1 and status = 1. A hardware-only gate has `clk_en` = 0 and status = 0.
- R9: Bit 4 of `rd_data` always equals `gate_status`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read-back, including status |
| hw_req | input | 1 | Auto-gate request from the idle detector (1 = clock needed) |
| clk_en | output | 1 | Effective clock-enable |
| gate_status | output | 1 | Settled gate state |

## Verification
The hardest case to reach from the ports is the window in which the status flag still shows the old state after `clk_en` has already moved. A check has to land on the last cycle before the flag updates and on the first cycle after it. The bench therefore counts edges from a write, and from a request change through the synchroniser, and samples both sides of that boundary. It runs five builds side by side on shared stimulus, so one write sequence shows how each mode ignores, honours or overrides the same bits.

// File: rtl/cg_pkg.sv
// Shared definitions for the clock gate: build variants and control-word bit positions.
package cg_pkg;
    typedef enum logic [1:0] {
        CG_NO_GATE = 2'd0,
        CG_HW_ONLY = 2'd1,
        CG_SW_ONLY = 2'd2,
        CG_HW_SW   = 2'd3
    } cg_mode_e;

    localparam int unsigned CG_WORD_W   = 32;
    localparam int unsigned CG_EN_POS   = 0;
    localparam int unsigned CG_SEL_POS  = 1;
    localparam int unsigned CG_STAT_POS = 4;

    // Mode implements a software enable bit.
    function automatic bit cg_has_en(cg_mode_e m);
        return (m == CG_SW_ONLY) || (m == CG_HW_SW);
    endfunction

    // Mode implements the hardware/software select bit.
    function automatic bit cg_has_sel(cg_mode_e m);
        return (m == CG_HW_SW);
    endfunction

    // Mode uses the hardware auto-gate request.
    function automatic bit cg_has_hw(cg_mode_e m);
        return (m == CG_HW_ONLY) || (m == CG_HW_SW);
    endfunction
endpackage

// File: rtl/cg_sync2.sv
// Two-flop synchroniser for one asynchronous level.
// Assumes: the input is a slow level, not a pulse narrower than a clock period.
module cg_sync2 #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Shift the level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cg_ctrl_reg.sv
// Control bits of the gate: enable and select.
// Bits the mode does not implement are held at 0 and ignore writes.
// Assumes: a write is a one-cycle strobe with data valid in the same cycle.
module cg_ctrl_reg
    import cg_pkg::*;
#(
    parameter cg_mode_e MODE = CG_HW_SW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_en_bit,
    input  logic wr_sel_bit,
    output logic en_q,
    output logic sel_q
);
    localparam bit HAS_EN  = cg_has_en(MODE);
    localparam bit HAS_SEL = cg_has_sel(MODE);

    // Hold the enable and select bits; software owns the gate after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= HAS_EN;
            sel_q <= HAS_SEL;
        end else if (wr_en) begin
            en_q  <= HAS_EN  & wr_en_bit;
            sel_q <= HAS_SEL & wr_sel_bit;
        end
    end
endmodule

// File: rtl/cg_enable_mux.sv
// Combinational choice of the effective clock-enable for the built mode.
// Assumes: hw_sync has already been synchronised to clk.
module cg_enable_mux
    import cg_pkg::*;
#(
    parameter cg_mode_e MODE       = CG_HW_SW,
    parameter bit       NO_DISABLE = 1'b0
) (
    input  logic hw_sync,
    input  logic en_q,
    input  logic sel_q,
    output logic clk_en
);
    logic unused_mux_in;
    assign unused_mux_in = hw_sync ^ en_q ^ sel_q;

    // Pick the enable source for the mode.
    always_comb begin
        unique case (MODE)
            CG_NO_GATE: clk_en = 1'b1;
            CG_HW_ONLY: clk_en = hw_sync;
            CG_SW_ONLY: clk_en = en_q;
            default:    clk_en = sel_q ? (NO_DISABLE | en_q) : hw_sync;
        endcase
    end
endmodule

// File: rtl/cg_settle.sv
// Delay line that models gate settling: the output trails the input by DEPTH edges.
// Assumes: RST_VAL matches the input's value during reset.
module cg_settle #(
    parameter int unsigned DEPTH   = 3,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] stage_q;

    // The first stage samples the live enable.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        // Each further stage adds one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/cg_gate.sv
// Top of the register-controlled clock gate.
// Combines the control bits, the synchronised auto-gate request and the settling status.
// Assumes: SETTLE lies between 2 and 4 (it is clamped into that range).
module cg_gate
    import cg_pkg::*;
#(
    parameter cg_mode_e    MODE       = CG_HW_SW,
    parameter bit          NO_DISABLE = 1'b0,
    parameter int unsigned SETTLE     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CG_WORD_W-1:0] wr_data,
    output logic [CG_WORD_W-1:0] rd_data,
    input  logic                 hw_req,
    output logic                 clk_en,
    output logic                 gate_status
);
    localparam int unsigned DEPTH  = (SETTLE < 2) ? 2 : ((SETTLE > 4) ? 4 : SETTLE);
    localparam bit          HAS_HW = cg_has_hw(MODE);
    localparam bit          RST_EN = (MODE != CG_HW_ONLY);

    logic hw_sync;
    logic en_q;
    logic sel_q;
    logic unused_wr;

    assign unused_wr = ^wr_data;

    if (HAS_HW) begin : g_hw
        cg_sync2 #(.RST_VAL(1'b0)) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (hw_req),
            .q     (hw_sync)
        );
    end else begin : g_no_hw
        logic unused_hw;
        assign unused_hw = hw_req;
        assign hw_sync   = 1'b0;
    end

    cg_ctrl_reg #(.MODE(MODE)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_en_bit  (wr_data[CG_EN_POS]),
        .wr_sel_bit (wr_data[CG_SEL_POS]),
        .en_q       (en_q),
        .sel_q      (sel_q)
    );

    cg_enable_mux #(.MODE(MODE), .NO_DISABLE(NO_DISABLE)) mux_i (
        .hw_sync (hw_sync),
        .en_q    (en_q),
        .sel_q   (sel_q),
        .clk_en  (clk_en)
    );

    if (MODE == CG_NO_GATE) begin : g_always_on
        assign gate_status = 1'b1;
    end else begin : g_settle
        cg_settle #(.DEPTH(DEPTH), .RST_VAL(RST_EN)) settle_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (clk_en),
            .q     (gate_status)
        );
    end

    // Assemble the read-back word; undefined bits are zero.
    always_comb begin
        rd_data              = '0;
        rd_data[CG_EN_POS]   = en_q;
        rd_data[CG_SEL_POS]  = sel_q;
        rd_data[CG_STAT_POS] = gate_status;
    end
endmodule

// File: rtl/cg_gate_chk.sv
// Property checker for cg_gate, attached by bind. Observes ports only.
module cg_gate_chk
    import cg_pkg::*;
#(
    parameter cg_mode_e    MODE       = CG_HW_SW,
    parameter bit          NO_DISABLE = 1'b0,
    parameter int unsigned SETTLE     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CG_WORD_W-1:0] rd_data,
    input logic                 hw_req,
    input logic                 clk_en,
    input logic                 gate_status
);
    localparam int unsigned DEPTH = (SETTLE < 2) ? 2 : ((SETTLE > 4) ? 4 : SETTLE);
    localparam logic [CG_WORD_W-1:0] LEGAL =
        (CG_WORD_W'(cg_has_en(MODE))  << CG_EN_POS)  |
        (CG_WORD_W'(cg_has_sel(MODE)) << CG_SEL_POS) |
        (CG_WORD_W'(1) << CG_STAT_POS);

    logic [1:0] since_rst;
    logic [2:0] stable_cnt;
    logic       prev_en;
    logic       hw_ctrl;
    logic       sw_ctrl;

    assign hw_ctrl = (MODE == CG_HW_ONLY) || (MODE == CG_HW_SW && !rd_data[CG_SEL_POS]);
    assign sw_ctrl = (MODE == CG_SW_ONLY) || (MODE == CG_HW_SW && rd_data[CG_SEL_POS]);

    // Count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Track how long clk_en has held its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_cnt <= '0;
            prev_en    <= clk_en;
        end else begin
            prev_en <= clk_en;
            if (clk_en != prev_en)            stable_cnt <= '0;
            else if (stable_cnt < 3'(DEPTH))  stable_cnt <= stable_cnt + 3'd1;
        end
    end

    AST_NO_GATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == CG_NO_GATE) |-> (clk_en && gate_status)); // R1
    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LEGAL) == '0); // R2
    AST_HW_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ctrl && since_rst == 2'd3) |-> (clk_en == $past(hw_req, 2))); // R3
    AST_SW_TRACKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ctrl && !NO_DISABLE) |-> (clk_en == rd_data[CG_EN_POS])); // R4
    AST_ND_HELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == CG_HW_SW && NO_DISABLE && rd_data[CG_SEL_POS]) |-> clk_en); // R6
    AST_STATUS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_en == clk_en && stable_cnt >= 3'(DEPTH - 1)) |-> (gate_status == clk_en)); // R7
    AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CG_STAT_POS] == gate_status); // R9
endmodule

bind cg_gate cg_gate_chk #(.MODE(MODE), .NO_DISABLE(NO_DISABLE), .SETTLE(SETTLE)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data     (rd_data),
    .hw_req      (hw_req),
    .clk_en      (clk_en),
    .gate_status (gate_status)
);

// File: tb/cg_gate_tb_top.sv
`timescale 1ns/1ps
module cg_gate_tb_top;
    import cg_pkg::*;

    typedef struct {
        int          dut;
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        hw_req = 1'b0;
    logic [31:0] rd_w [5];
    logic        ce_w [5];
    logic        st_w [5];
    item_t       exp_q [$];
    event        chk_ev;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    // 0: selectable, 1: selectable never-off, 2: software, 3: hardware, 4: no gate
    cg_gate #(.MODE(CG_HW_SW), .NO_DISABLE(1'b0), .SETTLE(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_w[0]),
        .hw_req(hw_req), .clk_en(ce_w[0]), .gate_status(st_w[0]));
    cg_gate #(.MODE(CG_HW_SW), .NO_DISABLE(1'b1), .SETTLE(3)) dut_nd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_w[1]),
        .hw_req(hw_req), .clk_en(ce_w[1]), .gate_status(st_w[1]));
    cg_gate #(.MODE(CG_SW_ONLY), .NO_DISABLE(1'b0), .SETTLE(3)) dut_sw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_w[2]),
        .hw_req(hw_req), .clk_en(ce_w[2]), .gate_status(st_w[2]));
    cg_gate #(.MODE(CG_HW_ONLY), .NO_DISABLE(1'b0), .SETTLE(3)) dut_hw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_w[3]),
        .hw_req(hw_req), .clk_en(ce_w[3]), .gate_status(st_w[3]));
    cg_gate #(.MODE(CG_NO_GATE), .NO_DISABLE(1'b0), .SETTLE(3)) dut_none (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_w[4]),
        .hw_req(hw_req), .clk_en(ce_w[4]), .gate_status(st_w[4]));

    function automatic logic [31:0] observe(int d, int k);
        if (k == 0) return {31'd0, ce_w[d]};
        if (k == 1) return {31'd0, st_w[d]};
        return rd_w[d];
    endfunction

    // Monitor: pops queued expectations and compares them against the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = observe(it.dut, it.kind);
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s dut%0d kind%0d actual=0x%08h expected=0x%08h",
                             it.req, it.dut, it.kind, act, it.exp);
                end
            end
        end
    end

    // Driver side: queue expected enable, status and read-back for one build.
    task automatic expect3(int d, logic ce, logic st, logic [31:0] rd, string req);
        exp_q.push_back('{d, 0, {31'd0, ce}, req});
        exp_q.push_back('{d, 1, {31'd0, st}, req});
        exp_q.push_back('{d, 2, rd, req});
    endtask

    task automatic expect_ce(int d, logic ce, string req);
        exp_q.push_back('{d, 0, {31'd0, ce}, req});
    endtask

    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(logic [31:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic set_hw(logic v);
        hw_req = v;
        @(negedge clk);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R8 / R1: state after reset
        expect3(0, 1, 1, 32'h13, "R8");
        expect3(1, 1, 1, 32'h13, "R8");
        expect3(2, 1, 1, 32'h11, "R8");
        expect3(3, 0, 0, 32'h00, "R8");
        expect3(4, 1, 1, 32'h10, "R1");
        flush();

        // R5 / R2: software control, enable off, junk in the undefined bits
        write(32'hFFFF_FFE2);
        expect3(0, 0, 1, 32'h12, "R5");
        expect3(1, 1, 1, 32'h12, "R6");
        expect3(2, 0, 1, 32'h10, "R4");
        expect3(3, 0, 0, 32'h00, "R2");
        expect3(4, 1, 1, 32'h10, "R1");
        flush();
        step(2);
        expect3(0, 0, 1, 32'h12, "R7");
        expect3(2, 0, 1, 32'h10, "R7");
        flush();
        step(1);
        expect3(0, 0, 0, 32'h02, "R7");
        expect3(2, 0, 0, 32'h00, "R7");
        expect3(1, 1, 1, 32'h12, "R6");
        flush();

        // R3: request rises; sync takes two edges, software-owned gate ignores it
        set_hw(1'b1);
        expect_ce(3, 0, "R3");
        flush();
        step(1);
        expect_ce(3, 1, "R3");
        expect_ce(0, 0, "R5");
        expect_ce(1, 1, "R6");
        flush();
        step(3);
        expect3(3, 1, 1, 32'h10, "R9");
        expect3(0, 0, 0, 32'h02, "R5");
        flush();

        // R5: hand the gate to hardware
        write(32'h0000_0000);
        expect3(0, 1, 0, 32'h00, "R5");
        expect3(1, 1, 1, 32'h10, "R5");
        expect3(2, 0, 0, 32'h00, "R4");
        flush();
        step(3);
        expect3(0, 1, 1, 32'h10, "R7");
        flush();

        // R3 / R5: request falls
        set_hw(1'b0);
        expect_ce(0, 1, "R5");
        expect_ce(3, 1, "R3");
        flush();
        step(1);
        expect_ce(0, 0, "R5");
        expect_ce(1, 0, "R5");
        expect_ce(3, 0, "R3");
        flush();
        step(2);
        expect3(0, 0, 1, 32'h10, "R7");
        flush();
        step(1);
        expect3(0, 0, 0, 32'h00, "R7");
        expect3(1, 0, 0, 32'h00, "R7");
        expect3(3, 0, 0, 32'h00, "R3");
        flush();

        // R5: enable written while hardware owns the gate has no effect on clk_en
        write(32'h0000_0001);
        expect3(0, 0, 0, 32'h01, "R5");
        expect3(1, 0, 0, 32'h01, "R5");
        expect3(2, 1, 0, 32'h01, "R4");
        expect3(4, 1, 1, 32'h10, "R1");
        flush();

        // R5: back to software with enable set
        write(32'h0000_0003);
        expect3(0, 1, 0, 32'h03, "R5");
        expect3(2, 1, 0, 32'h01, "R2");
        flush();
        step(3);
        expect3(0, 1, 1, 32'h13, "R9");
        expect3(2, 1, 1, 32'h11, "R9");
        expect3(3, 0, 0, 32'h00, "R2");
        flush();

        // R6: never-off gate under software with enable cleared stays on
        write(32'h0000_0002);
        expect3(1, 1, 1, 32'h12, "R6");
        expect_ce(0, 0, "R5");
        flush();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule